// File: doc/BRIEF.md
# Snooping Bus Transaction Sequencer

This block runs one shared, cache-coherent system bus. Several caches raise requests. A round-robin arbiter picks one of them. The sequencer then carries the granted transaction through a fixed four-cycle address phase:

- one arbitration cycle,
- one cycle that drives the address,
- two snoop-wait cycles, which give the other caches time to report and memory time to get ready.

A data phase follows the address phase. It moves one 128-byte cache block as eight consecutive 128-bit beats. Reads and writes use the same phase pattern. On a write, the bus carries the writer's data. On a read, it carries the data from the memory side.

The parameter `SPLIT` sets the operating mode. With `SPLIT = 0`, address and data phases strictly alternate, so each block takes 12 bus cycles. With `SPLIT = 1`, the address and data resources are separate. The next transaction's address phase then runs while the current beats stream. A completed address phase waits in a holding state until the data path frees, which gives 8 cycles per block under continuous load.

Address-phase states:
- `A_IDLE`: no transaction in progress.
- `A_ARB`: the arbitration cycle.
- `A_ADDR`: the address cycle.
- `A_SNP1` and `A_SNP2`: the two snoop-wait cycles.
- `A_HOLD`: a completed address phase waiting for the data path to free.

Address-phase transitions:
- `A_IDLE -> A_ARB` when a request is present and arbitration is allowed. Arbitration is always allowed in split mode. In sequential mode it is allowed only when the data path is free.
- `A_ARB -> A_ADDR` when there is a winner, or `A_ARB -> A_IDLE` when there is none.
- `A_ADDR -> A_SNP1 -> A_SNP2`.
- `A_SNP2` or `A_HOLD` moves on the handoff, which happens once the data path is idle or on its last beat. After the handoff, the next state is `A_ARB` in split mode when a request is waiting, and `A_IDLE` otherwise. Without a handoff, the next state is `A_HOLD`.

Data-path states:
- `D_IDLE` and `D_BEAT`.
- `D_IDLE -> D_BEAT` on a handoff.
- `D_BEAT` stays in `D_BEAT` until the eighth beat. On the eighth beat, a new handoff restarts it in the same cycle; otherwise it returns to `D_IDLE`.

Top module: `snoop_bus_seq`

## Requirements
- R1: While `rst_n` is low, `grant`, `bus_addr_valid`, `d_valid` and `d_last` are all 0.
- R2: Arbitration is round-robin. The search starts one position past the previous winner, and the first winner after reset is the lowest-numbered requester. `grant[i]` is one-hot for master i. It is asserted from the arbitration cycle until the transaction hands off to the data path, and it is unchanged during the snoop-wait cycles.
- R3: The address cycle follows the arbitration cycle directly. In that cycle `bus_addr_valid` is 1, and `bus_addr` and `bus_write` carry the winner's `m_addr` and `m_write`. The first data beat comes exactly 3 cycles after the address cycle in sequential mode, and at least 3 cycles after it in split mode.
- R4: Each transaction has exactly 8 consecutive cycles with `d_valid` high. `d_last` is high on the eighth of them only.
- R5: In sequential mode there is no address-cycle activity while `d_valid` is high. Under continuous requests, successive blocks complete 12 cycles apart.
- R6: In split mode a data phase starts only after the previous one's eighth beat. Under continuous requests, successive blocks complete 8 cycles apart.
- R7: `resp_shared` and `resp_dirty` are the OR of `snp_shared` and `snp_dirty`, sampled at the end of the second snoop-wait cycle. They hold that value through all of that transaction's beats.
- R8: Transactions complete in grant order. During the beats, `d_master` and `d_write` identify the transaction. `bus_data` carries slice `d_master` of `m_wdata` for a write (`d_write` = 1) and `mem_rdata` for a read.
- R9: From an idle bus, a request raised mid-cycle gives an arbitration cycle on the next cycle, and the first beat 4 cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Per-master request |
| m_write | input | N_MST | Per-master write flag (1 = write) |
| m_addr | input | N_MST*ADDR_W | Per-master block address, master i in slice i |
| m_wdata | input | N_MST*DATA_W | Per-master write data, master i in slice i |
| mem_rdata | input | DATA_W | Read data from memory or the owning cache |
| snp_shared | input | N_MST | Snoop shared indication from each cache |
| snp_dirty | input | N_MST | Snoop dirty indication from each cache |
| grant | output | N_MST | One-hot grant, held through the address phase |
| bus_addr_valid | output | 1 | High during the address cycle |
| bus_addr | output | ADDR_W | Address of the current address phase |
| bus_write | output | 1 | Write flag of the current address phase |
| d_valid | output | 1 | Data beat valid |
| d_last | output | 1 | Eighth beat of the block |
| d_master | output | $clog2(N_MST) | Master that owns the data phase |
| d_write | output | 1 | Data phase is a write |
| bus_data | output | DATA_W | Beat data |
| resp_shared | output | 1 | Latched snoop shared result |
| resp_dirty | output | 1 | Latched snoop dirty result |

## Verification
The assertions assume that a requester keeps `req` high until its grant shows in the address cycle. They also assume that `m_addr` and `m_write` stay stable while that request is pending. The bench keeps to this: it changes a master's address and write flag only when it raises that request or when it sees the master granted. Snoop lines and read data change freely every cycle. The bench records the snoop values at the exact cycle the sequencer samples them. Stimulus is driven only at falling edges, after the outputs have been checked. This keeps every value stable across the rising edge.

// File: rtl/snb_pkg.sv
package snb_pkg;
    typedef enum logic [2:0] {
        A_IDLE,
        A_ARB,
        A_ADDR,
        A_SNP1,
        A_SNP2,
        A_HOLD
    } aph_e;

    typedef enum logic {
        D_IDLE,
        D_BEAT
    } dph_e;
endpackage

// File: rtl/snb_rr_arb.sv
module snb_rr_arb #(
    parameter int N_MST = 4,
    localparam int IDX_W = $clog2(N_MST)
) (
    input  logic [N_MST-1:0] req,
    input  logic [IDX_W-1:0] last_idx,
    output logic             win_vld,
    output logic [IDX_W-1:0] win_idx,
    output logic [N_MST-1:0] win_oh
);
    int cand;

    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        cand    = 0;
        for (int k = 1; k <= N_MST; k++) begin
            cand = int'(last_idx) + k;
            if (cand >= N_MST) cand = cand - N_MST;
            if (!win_vld && req[cand]) begin
                win_vld = 1'b1;
                win_idx = IDX_W'(cand);
            end
        end
        win_oh = '0;
        if (win_vld) win_oh[win_idx] = 1'b1;
    end
endmodule

// File: rtl/snb_beat_ctr.sv
module snb_beat_ctr
    import snb_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int CW = $clog2(BEATS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic valid,
    output logic last
);
    dph_e          d_state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_state <= D_IDLE;
            cnt     <= '0;
        end else begin
            unique case (d_state)
                D_IDLE: begin
                    if (start) begin
                        d_state <= D_BEAT;
                        cnt     <= '0;
                    end
                end
                D_BEAT: begin
                    if (cnt == CW'(BEATS - 1)) begin
                        cnt <= '0;
                        if (!start) d_state <= D_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: d_state <= D_IDLE;
            endcase
        end
    end

    always_comb begin
        valid = (d_state == D_BEAT);
        last  = (d_state == D_BEAT) && (cnt == CW'(BEATS - 1));
    end

    // R4: a run of beats is never cut short
    p_beats_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !last) |=> valid);

    // R6: a new data phase is only launched into a free data path
    p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (!valid || last));
endmodule

// File: rtl/snoop_bus_seq.sv
module snoop_bus_seq
    import snb_pkg::*;
#(
    parameter int N_MST       = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 128,
    parameter int BLOCK_BYTES = 128,
    parameter int SPLIT       = 0,
    localparam int IDX_W = $clog2(N_MST),
    localparam int BEATS = (BLOCK_BYTES * 8) / DATA_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_MST-1:0]          req,
    input  logic [N_MST-1:0]          m_write,
    input  logic [N_MST*ADDR_W-1:0]   m_addr,
    input  logic [N_MST*DATA_W-1:0]   m_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    input  logic [N_MST-1:0]          snp_shared,
    input  logic [N_MST-1:0]          snp_dirty,
    output logic [N_MST-1:0]          grant,
    output logic                      bus_addr_valid,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_write,
    output logic                      d_valid,
    output logic                      d_last,
    output logic [IDX_W-1:0]          d_master,
    output logic                      d_write,
    output logic [DATA_W-1:0]         bus_data,
    output logic                      resp_shared,
    output logic                      resp_dirty
);
    aph_e              a_state, a_next;
    logic [IDX_W-1:0]  owner, rr_last;
    logic              cap_write;
    logic [ADDR_W-1:0] cap_addr;
    logic              hold_sh, hold_dt;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    logic [N_MST-1:0]  win_oh;
    logic              data_free, launch, may_arb;
    logic              snp_sh_now, snp_dt_now;
    logic [ADDR_W-1:0] win_addr;
    logic              win_write;

    snb_rr_arb #(.N_MST(N_MST)) u_arb (
        .req      (req),
        .last_idx (rr_last),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_oh   (win_oh)
    );

    snb_beat_ctr #(.BEATS(BEATS)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch),
        .valid (d_valid),
        .last  (d_last)
    );

    assign data_free = !d_valid || d_last;
    assign launch    = ((a_state == A_SNP2) || (a_state == A_HOLD)) && data_free;

    generate
        if (SPLIT != 0) begin : g_split
            assign may_arb = 1'b1;
        end else begin : g_seq
            assign may_arb = data_free;
        end
    endgenerate

    always_comb begin
        snp_sh_now = (a_state == A_SNP2) ? |snp_shared : hold_sh;
        snp_dt_now = (a_state == A_SNP2) ? |snp_dirty  : hold_dt;
        win_addr   = '0;
        win_write  = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (win_idx == IDX_W'(i)) begin
                win_addr  = m_addr[i*ADDR_W +: ADDR_W];
                win_write = m_write[i];
            end
        end
    end

    // Next-state logic of the address phase
    always_comb begin
        a_next = a_state;
        unique case (a_state)
            A_IDLE: if (|req && may_arb) a_next = A_ARB;
            A_ARB:  a_next = win_vld ? A_ADDR : A_IDLE;
            A_ADDR: a_next = A_SNP1;
            A_SNP1: a_next = A_SNP2;
            A_SNP2, A_HOLD: begin
                if (launch) a_next = ((SPLIT != 0) && |req) ? A_ARB : A_IDLE;
                else        a_next = A_HOLD;
            end
            default: a_next = A_IDLE;
        endcase
    end

    // State register and per-transaction captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_state     <= A_IDLE;
            owner       <= '0;
            rr_last     <= IDX_W'(N_MST - 1);
            cap_write   <= 1'b0;
            cap_addr    <= '0;
            hold_sh     <= 1'b0;
            hold_dt     <= 1'b0;
            d_master    <= '0;
            d_write     <= 1'b0;
            resp_shared <= 1'b0;
            resp_dirty  <= 1'b0;
        end else begin
            a_state <= a_next;
            if (a_state == A_ARB && win_vld) begin
                owner     <= win_idx;
                rr_last   <= win_idx;
                cap_write <= win_write;
                cap_addr  <= win_addr;
            end
            if (a_state == A_SNP2) begin
                hold_sh <= |snp_shared;
                hold_dt <= |snp_dirty;
            end
            if (launch) begin
                d_master    <= owner;
                d_write     <= cap_write;
                resp_shared <= snp_sh_now;
                resp_dirty  <= snp_dt_now;
            end
        end
    end

    // Outputs
    always_comb begin
        grant = '0;
        unique case (a_state)
            A_ARB:                          grant = win_oh;
            A_ADDR, A_SNP1, A_SNP2, A_HOLD: grant[owner] = 1'b1;
            default:                        grant = '0;
        endcase
        bus_addr_valid = (a_state == A_ADDR);
        bus_addr       = cap_addr;
        bus_write      = cap_write;
        bus_data       = mem_rdata;
        if (d_write) begin
            for (int i = 0; i < N_MST; i++) begin
                if (d_master == IDX_W'(i)) bus_data = m_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    // R2: at most one grant at a time
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: grant does not move during the snoop wait
    p_grant_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_state == A_SNP1) |=> $stable(grant));

    // R3: beats only begin after a completed address phase
    p_handoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_valid) |-> $past(a_state == A_SNP2 || a_state == A_HOLD));

    generate
        if (SPLIT == 0) begin : g_seq_chk
            // R5: no address-phase overlap in sequential mode
            p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
                d_valid |-> !(a_state inside {A_ARB, A_ADDR, A_SNP1, A_SNP2}));
        end
    endgenerate
endmodule

// File: tb/snoop_bus_seq_env.sv
module snoop_bus_seq_env #(
    parameter int SPLIT = 0,
    parameter int SEED  = 1
) (
    input logic clk
);
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int DW = 128;

    logic            rst_n;
    logic [N-1:0]    req, m_write, snp_sh, snp_dt;
    logic [N*AW-1:0] m_addr;
    logic [N*DW-1:0] m_wdata;
    logic [DW-1:0]   mem_rdata;
    logic [N-1:0]    grant;
    logic            addr_valid, bus_write, d_valid, d_last, d_write, r_sh, r_dt;
    logic [AW-1:0]   bus_addr;
    logic [1:0]      d_master;
    logic [DW-1:0]   bus_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    snoop_bus_seq #(.N_MST(N), .ADDR_W(AW), .DATA_W(DW), .BLOCK_BYTES(128), .SPLIT(SPLIT)) u_snoop_bus_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .m_write(m_write), .m_addr(m_addr),
        .m_wdata(m_wdata), .mem_rdata(mem_rdata), .snp_shared(snp_sh), .snp_dirty(snp_dt),
        .grant(grant), .bus_addr_valid(addr_valid), .bus_addr(bus_addr), .bus_write(bus_write),
        .d_valid(d_valid), .d_last(d_last), .d_master(d_master), .d_write(d_write),
        .bus_data(bus_data), .resp_shared(r_sh), .resp_dirty(r_dt)
    );

    function automatic logic [DW-1:0] wdata_of(input int i);
        return {4{32'hC0DE_0000 + 32'(i * 17)}};
    endfunction

    function automatic int rr_pick(input logic [N-1:0] r, input int last);
        for (int k = 1; k <= N; k++) begin
            if (r[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (split=%0d) actual=%h expected=%h", tag, SPLIT, act, exp);
        end
    endtask

    logic [N-1:0]  req_prev = '0;
    logic [AW-1:0] cur_addr [N];
    logic          cur_wr   [N];
    int q_m [16], q_cyc [16];
    bit q_w [16], q_sh [16], q_dt [16];
    int qh = 0, qt = 0, pend = 0, beat = 0, neg = 0;
    int rr_last = N - 1, t_req0 = -1, nblk = 0, last_neg = 0;
    bit first_lat_done = 0;

    initial begin
        void'($urandom(SEED));
        rst_n = 0; req = '0; m_write = '0; m_addr = '0; snp_sh = '0; snp_dt = '0;
        mem_rdata = '0;
        for (int i = 0; i < N; i++) begin
            m_wdata[i*DW +: DW] = wdata_of(i);
            cur_addr[i] = 32'h1000 * AW'(i + 1);
            cur_wr[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        int mode, w, gi, gap;
        bit rec;
        neg++;
        mode = (neg < 8) ? 0 : (neg < 138) ? 1 : (neg < 3138) ? 2 : 3;
        gi = -1;
        rec = 0;
        if (!rst_n) begin
            chk(grant == 0 && !addr_valid && !d_valid && !d_last, "R1 reset outputs",
                {grant, addr_valid, d_valid, d_last}, '0);
        end else begin
            if (addr_valid) begin
                w = rr_pick(req_prev, rr_last);
                chk(w >= 0 && grant == (4'b1 << w), "R2 round-robin grant", grant, 4'b1 << w);
                if (w >= 0) begin
                    chk(bus_addr == cur_addr[w], "R3 address cycle address", bus_addr, cur_addr[w]);
                    chk(bus_write == cur_wr[w], "R3 address cycle write flag", bus_write, cur_wr[w]);
                    q_m[qt % 16] = w; q_w[qt % 16] = cur_wr[w]; q_cyc[qt % 16] = neg;
                    qt++;
                    rr_last = w;
                    gi = w;
                end
                pend = 2;
            end else if (pend > 0) begin
                chk(grant == (4'b1 << rr_last), "R2 grant held in snoop wait", grant, 4'b1 << rr_last);
                pend--;
                rec = (pend == 0);
            end
            if (d_valid) begin
                if (beat == 0) begin
                    chk(qh != qt, "R8 beats without a transaction", 1, 0);
                    chk(d_master == 2'(q_m[qh % 16]), "R8 grant order master", d_master, q_m[qh % 16]);
                    chk(d_write == q_w[qh % 16], "R8 data phase direction", d_write, q_w[qh % 16]);
                    gap = neg - q_cyc[qh % 16];
                    if (SPLIT == 0) chk(gap == 3, "R3 address to first beat", gap, 3);
                    else            chk(gap >= 3, "R3 address to first beat", gap, 3);
                    if (!first_lat_done && t_req0 >= 0) begin
                        chk(neg == t_req0 + 5, "R9 idle latency", neg - t_req0, 5);
                        first_lat_done = 1;
                    end
                end
                chk(r_sh == q_sh[qh % 16] && r_dt == q_dt[qh % 16], "R7 snoop response",
                    {r_sh, r_dt}, {q_sh[qh % 16], q_dt[qh % 16]});
                chk(bus_data == (d_write ? wdata_of(int'(d_master)) : mem_rdata), "R8 beat data",
                    bus_data, d_write ? wdata_of(int'(d_master)) : mem_rdata);
                chk(d_last == (beat == 7), "R4 last beat strobe", d_last, beat == 7);
                if (SPLIT == 0) chk(!addr_valid, "R5 no overlap in sequential mode", addr_valid, 0);
                beat++;
                if (beat == 8) begin
                    beat = 0;
                    qh++;
                    if (mode == 1) begin
                        if (nblk >= 1) begin
                            if (SPLIT == 0) chk(neg - last_neg == 12, "R5 block spacing", neg - last_neg, 12);
                            else            chk(neg - last_neg == 8, "R6 block spacing", neg - last_neg, 8);
                        end
                        nblk++;
                        last_neg = neg;
                    end
                end
            end else if (beat != 0) begin
                chk(0, "R4 beat run broken", beat, 8);
                beat = 0;
                qh++;
            end
        end

        // drive phase
        rst_n = (neg >= 4);
        snp_sh = 4'($urandom);
        snp_dt = 4'($urandom);
        mem_rdata = {$urandom, $urandom, $urandom, $urandom};
        if (rec) begin
            q_sh[(qt - 1) % 16] = |snp_sh;
            q_dt[(qt - 1) % 16] = |snp_dt;
        end
        for (int i = 0; i < N; i++) begin
            if (gi == i) begin
                cur_addr[i] = $urandom & 32'hFFFF_FF80;
                cur_wr[i] = 1'($urandom);
                if (mode == 3 || (mode == 2 && $urandom % 2 == 0)) req[i] = 1'b0;
            end else if (mode == 2 && !req[i] && $urandom % 4 == 0) begin
                cur_addr[i] = $urandom & 32'hFFFF_FF80;
                cur_wr[i] = 1'($urandom);
                req[i] = 1'b1;
            end
            if (mode == 1) req[i] = 1'b1;
            m_addr[i*AW +: AW] = cur_addr[i];
            m_write[i] = cur_wr[i];
        end
        if (mode == 1 && t_req0 < 0) t_req0 = neg;
        req_prev = req;
        if (mode == 3 && req == 0 && qh == qt && !d_valid && pend == 0 && !done) done = 1;
    end
endmodule

// File: tb/snoop_bus_seq_bench.sv
module snoop_bus_seq_bench;
    logic clk = 0;
    int   cyc = 0;
    int   total, failed;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    snoop_bus_seq_env #(.SPLIT(0), .SEED(11)) u_env_seq (.clk(clk));
    snoop_bus_seq_env #(.SPLIT(1), .SEED(23)) u_env_spl (.clk(clk));

    initial begin
        wait ((u_env_seq.done && u_env_spl.done) || cyc > 100000);
        total  = u_env_seq.n_checks + u_env_spl.n_checks;
        failed = u_env_seq.n_fail + u_env_spl.n_fail;
        if (!(u_env_seq.done && u_env_spl.done)) begin
            total++;
            failed++;
            $display("FAIL watchdog expired: actual=%0d cycles expected=done", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", total, failed);
        $finish;
    end
endmodule